// File: doc/BRIEF.md
# Triple-Channel Speed Filter and Voter

This block accepts period or speed samples from three redundant Hall measurement channels. Each channel has its own valid strobe. Each channel feeds its own first-order low-pass filter. The filter keeps three quarters of its previous state and adds one quarter of the new sample, using only shifts and adds. The three filtered values are then compared, and a single trusted value is produced from them. A single channel that reads wrong or goes silent therefore cannot corrupt or stop the speed result.

The block watches each channel for silence. A channel that delivers no sample within a timeout window is marked stale and left out of the vote. It rejoins the vote as soon as it delivers a sample again. With three live channels the output is their median. With two live channels the output is their average. With fewer than two, no result is issued.

A result is strobed once every live channel has updated since the previous result. The result comes with per-channel disagreement flags. A flag is raised when a channel's filtered value sits further from the voted value than a tolerance supplied at an input port.

Top module: `hall_speed_voter`

## Requirements
- R1: The first valid sample a channel receives after reset loads that channel's filter state directly, with no smoothing.
- R2: Every later valid sample updates the channel's filter state to floor((3 × state + sample) / 4), computed without overflow.
- R3: When all three channels are live, `v_data_o` carries the median of the three filtered values.
- R4: `v_valid_o` pulses high for one cycle, one clock after the edge at which the last still-pending live channel took its sample. Every live channel must have updated since the previous pulse. `v_data_o` and `disagree_o` change only together with that pulse.
- R5: Bit i of `disagree_o` is 1 when channel i is live and the absolute difference between its filtered value and the voted value exceeds `tol_i`. A channel that is not live always shows 0.
- R6: Bit i of `stale_o` rises once TIMEOUT clock cycles have passed since channel i's last valid sample, or since reset. It clears at the edge where channel i next takes a sample.
- R7: When exactly two channels are live, `v_data_o` is floor((a + b) / 2) of their filtered values.
- R8: While fewer than two channels are live, `v_valid_o` stays low.
- R9: During and right after reset, `v_valid_o`, `v_data_o`, `disagree_o` and `stale_o` are all 0.

A channel is live when it has taken at least one sample since reset and is not stale. Bit i of every 3-bit port belongs to channel i. Channel i's sample occupies bits [i·W +: W] of `s_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid_i | input | 3 | Per-channel sample strobe |
| s_data_i | input | 3·W | Per-channel samples, channel i in bits [i·W +: W] |
| tol_i | input | W | Disagreement tolerance |
| v_valid_o | output | 1 | Voted result strobe |
| v_data_o | output | W | Voted filtered value |
| disagree_o | output | 3 | Per-channel disagreement flags, updated with the result |
| stale_o | output | 3 | Per-channel timeout flags |

## Verification
The bench builds the block with W = 8 and TIMEOUT = 16. At W = 8, a long sweep of sample triples covers the whole value range: outliers at both ends, varying tolerances, and three different update orders. Each result is checked against an arithmetic model of the filter and the median. The short timeout makes it cheap to let one channel and then two go silent. This reaches the pair-average mode, the no-result mode and a stale channel rejoining the vote, all within a few hundred cycles.

// File: rtl/hsv_pkg.sv
package hsv_pkg;
  localparam int NCH = 3;

  typedef enum logic [1:0] {
    VM_NONE = 2'd0,
    VM_PAIR = 2'd1,
    VM_TRIO = 2'd2
  } vote_mode_e;
endpackage

// File: rtl/hsv_chan.sv
module hsv_chan #(
  parameter int W       = 16,
  parameter int TIMEOUT = 50000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_vld,
  input  logic [W-1:0] smp,
  output logic [W-1:0] filt_o,
  output logic         primed_o,
  output logic         stale_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] CLIM = CW'(TIMEOUT);

  // one smoothing step: three parts old, one part new, divided by four
  function automatic logic [W-1:0] iir_next(input logic [W-1:0] old_v,
                                            input logic [W-1:0] new_v);
    logic [W+1:0] acc;
    acc = ({2'b00, old_v} << 1) + {2'b00, old_v} + {2'b00, new_v};
    return acc[W+1:2];
  endfunction

  logic [W-1:0]  state_q;
  logic          primed_q;
  logic [CW-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= '0;
      primed_q <= 1'b0;
    end else if (smp_vld) begin
      primed_q <= 1'b1;
      state_q  <= primed_q ? iir_next(state_q, smp) : smp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              idle_q <= '0;
    else if (smp_vld)        idle_q <= '0;
    else if (idle_q != CLIM) idle_q <= idle_q + 1'b1;
  end

  assign filt_o   = state_q;
  assign primed_o = primed_q;
  assign stale_o  = (idle_q == CLIM);
endmodule

// File: rtl/hsv_vote.sv
module hsv_vote
  import hsv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] f0,
  input  logic [W-1:0] f1,
  input  logic [W-1:0] f2,
  input  logic [2:0]   alive,
  input  logic [W-1:0] tol,
  output vote_mode_e   mode,
  output logic [W-1:0] ref_val,
  output logic [2:0]   dis
);
  function automatic logic [W-1:0] med3(input logic [W-1:0] a,
                                        input logic [W-1:0] b,
                                        input logic [W-1:0] c);
    logic [W-1:0] lo, hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    if (c < lo)      return lo;
    else if (c > hi) return hi;
    else             return c;
  endfunction

  function automatic logic [W-1:0] avg2(input logic [W-1:0] a,
                                        input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W:1];
  endfunction

  function automatic logic [W-1:0] absdiff(input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  always_comb begin
    mode    = VM_NONE;
    ref_val = '0;
    unique case (alive)
      3'b111: begin mode = VM_TRIO; ref_val = med3(f0, f1, f2); end
      3'b011: begin mode = VM_PAIR; ref_val = avg2(f0, f1); end
      3'b101: begin mode = VM_PAIR; ref_val = avg2(f0, f2); end
      3'b110: begin mode = VM_PAIR; ref_val = avg2(f1, f2); end
      default: begin mode = VM_NONE; ref_val = '0; end
    endcase
  end

  always_comb begin
    dis[0] = alive[0] && (absdiff(f0, ref_val) > tol);
    dis[1] = alive[1] && (absdiff(f1, ref_val) > tol);
    dis[2] = alive[2] && (absdiff(f2, ref_val) > tol);
  end
endmodule

// File: rtl/hall_speed_voter.sv
module hall_speed_voter
  import hsv_pkg::*;
#(
  parameter int W       = 16,
  parameter int TIMEOUT = 50000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     s_valid_i,
  input  logic [3*W-1:0] s_data_i,
  input  logic [W-1:0]   tol_i,
  output logic           v_valid_o,
  output logic [W-1:0]   v_data_o,
  output logic [2:0]     disagree_o,
  output logic [2:0]     stale_o
);
  logic [W-1:0]   filt [NCH];
  logic [3*W-1:0] filt_flat;
  logic [2:0]     primed, stale, alive, pend;
  logic           fire;
  vote_mode_e     mode;
  logic [W-1:0]   ref_val;
  logic [2:0]     dis;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    hsv_chan #(.W(W), .TIMEOUT(TIMEOUT)) chan_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_vld (s_valid_i[g]),
      .smp     (s_data_i[g*W +: W]),
      .filt_o  (filt[g]),
      .primed_o(primed[g]),
      .stale_o (stale[g])
    );
    assign filt_flat[g*W +: W] = filt[g];
  end

  assign alive   = primed & ~stale;
  assign stale_o = stale;

  hsv_vote #(.W(W)) vote_i (
    .f0     (filt[0]),
    .f1     (filt[1]),
    .f2     (filt[2]),
    .alive  (alive),
    .tol    (tol_i),
    .mode   (mode),
    .ref_val(ref_val),
    .dis    (dis)
  );

  // a result is due when every live channel has a fresh update
  assign fire = (mode != VM_NONE) && ((pend | ~alive) == 3'b111) && (|(pend & alive));

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (fire ? 3'b000 : pend) | s_valid_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_valid_o  <= 1'b0;
      v_data_o   <= '0;
      disagree_o <= '0;
    end else begin
      v_valid_o <= fire;
      if (fire) begin
        v_data_o   <= ref_val;
        disagree_o <= dis;
      end
    end
  end
endmodule

// File: rtl/hsv_checker.sv
module hsv_checker #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     s_valid_i,
  input logic           v_valid_o,
  input logic [W-1:0]   v_data_o,
  input logic [2:0]     disagree_o,
  input logic [2:0]     stale_o,
  input logic [2:0]     alive,
  input logic           fire,
  input logic [3*W-1:0] filt_flat
);
  logic [W-1:0] a, b, c, lo_c, hi_c, lo_q, hi_q;
  assign a = filt_flat[0 +: W];
  assign b = filt_flat[W +: W];
  assign c = filt_flat[2*W +: W];
  always_comb begin
    lo_c = (a < b) ? a : b;
    if (c < lo_c) lo_c = c;
    hi_c = (a > b) ? a : b;
    if (c > hi_c) hi_c = c;
  end
  always_ff @(posedge clk) begin
    lo_q <= lo_c;
    hi_q <= hi_c;
  end

  // R4
  fire_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> v_valid_o);

  // R8
  few_alive_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(alive) < 2) |=> !v_valid_o);

  // R6
  sample_clears_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid_i != 3'b000) |=> ((stale_o & $past(s_valid_i)) == 3'b000));

  // R5
  dead_no_disagree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_valid_o |-> ((disagree_o & ~$past(alive)) == 3'b000));

  // R3
  median_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_valid_o && ($past(alive) == 3'b111)) |-> (v_data_o >= lo_q && v_data_o <= hi_q));

  // R4
  data_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v_valid_o |-> $stable(v_data_o));
endmodule

bind hall_speed_voter hsv_checker #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid_i (s_valid_i),
  .v_valid_o (v_valid_o),
  .v_data_o  (v_data_o),
  .disagree_o(disagree_o),
  .stale_o   (stale_o),
  .alive     (alive),
  .fire      (fire),
  .filt_flat (filt_flat)
);

// File: tb/hall_speed_voter_tb_top.sv
`timescale 1ns/1ps
module hall_speed_voter_tb_top;
  localparam int W = 8;
  localparam int TO = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     s_valid_i = '0;
  logic [3*W-1:0] s_data_i = '0;
  logic [W-1:0]   tol_i = '0;
  logic           v_valid_o;
  logic [W-1:0]   v_data_o;
  logic [2:0]     disagree_o, stale_o;

  always #10 clk = ~clk;

  hall_speed_voter #(.W(W), .TIMEOUT(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
    .tol_i(tol_i), .v_valid_o(v_valid_o), .v_data_o(v_data_o),
    .disagree_o(disagree_o), .stale_o(stale_o));

  int n_chk = 0, n_fail = 0, cyc = 0;
  int mf[3];
  bit mp[3];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // model: R1 load, R2 smoothing
  function automatic void model_smp(input int ch, input int v);
    if (!mp[ch]) begin mf[ch] = v; mp[ch] = 1; end
    else mf[ch] = (mf[ch] * 3 + v) / 4;
  endfunction

  function automatic int med(input int x, input int y, input int z);
    int t[3];
    t[0] = x; t[1] = y; t[2] = z;
    t.sort();
    return t[1];
  endfunction

  function automatic int adiff(input int x, input int y);
    return (x > y) ? x - y : y - x;
  endfunction

  // drive the channels in mask with the given samples for one cycle
  task automatic drive(input logic [2:0] mask, input int v0, input int v1, input int v2);
    s_valid_i = mask;
    s_data_i = {8'(v2), 8'(v1), 8'(v0)};
    if (mask[0]) model_smp(0, v0);
    if (mask[1]) model_smp(1, v1);
    if (mask[2]) model_smp(2, v2);
    @(negedge clk);
    s_valid_i = '0;
  endtask

  // check the result expected one cycle after the last drive
  task automatic expect_out(input logic [2:0] live, input string tag);
    int r;
    logic [2:0] d;
    if (live == 3'b111) r = med(mf[0], mf[1], mf[2]);
    else if (live == 3'b011) r = (mf[0] + mf[1]) / 2;
    else if (live == 3'b101) r = (mf[0] + mf[2]) / 2;
    else r = (mf[1] + mf[2]) / 2;
    for (int i = 0; i < 3; i++) d[i] = live[i] && (adiff(mf[i], r) > int'(tol_i));
    @(negedge clk);
    chk(v_valid_o == 1'b1, {tag, " R4 valid"}, int'(v_valid_o), 1);
    chk(int'(v_data_o) == r, tag, int'(v_data_o), r);
    chk(disagree_o == d, {tag, " R5 disagree"}, int'(disagree_o), int'(d));
    @(negedge clk);
    chk(v_valid_o == 1'b0, "R4 single pulse", int'(v_valid_o), 0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin mf[i] = 0; mp[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(v_valid_o == 0 && v_data_o == 0, "R9 outputs", int'(v_data_o), 0);
    chk(disagree_o == 0 && stale_o == 0, "R9 flags", int'({disagree_o, stale_o}), 0);

    // R1: first samples loaded directly, median exact
    tol_i = 8'd5;
    drive(3'b111, 40, 200, 90);
    expect_out(3'b111, "R1 first load / R3 median");

    // R2 R3 R5: sweep, three update orders
    for (int r = 0; r < 240; r++) begin
      int v0, v1, v2;
      v0 = (r * 37 + 11) % 256;
      v1 = (r * 91 + 3) % 256;
      v2 = (r % 7 == 0) ? 255 : ((r % 11 == 0) ? 0 : (r * 53 + 100) % 256);
      tol_i = 8'((r % 8) * 9);
      case (r % 3)
        0: drive(3'b111, v0, v1, v2);
        1: begin
          drive(3'b001, v0, 0, 0);
          chk(v_valid_o == 0, "R4 pending 1/3", int'(v_valid_o), 0);
          drive(3'b010, 0, v1, 0);
          chk(v_valid_o == 0, "R4 pending 2/3", int'(v_valid_o), 0);
          drive(3'b100, 0, 0, v2);
        end
        default: begin
          drive(3'b100, 0, 0, v2);
          drive(3'b011, v0, v1, 0);
        end
      endcase
      expect_out(3'b111, "R2 R3 sweep");
    end

    // R6 R7: let channel 2 go silent
    tol_i = 8'd3;
    for (int k = 0; k < 6; k++) begin
      drive(3'b011, 60 + k, 70, 0);
      repeat (4) @(negedge clk);
    end
    chk(stale_o == 3'b100, "R6 stale after timeout", int'(stale_o), 4);
    for (int k = 0; k < 8; k++) begin
      drive(3'b011, 17 * k + 1, 250 - 20 * k, 0);
      expect_out(3'b011, "R7 pair average");
    end

    // R6: channel 2 rejoins
    drive(3'b100, 0, 0, 120);
    chk(stale_o == 3'b000, "R6 stale clears", int'(stale_o), 0);
    drive(3'b011, 100, 140, 0);
    expect_out(3'b111, "R3 after rejoin");

    // R8: only channel 0 keeps going
    for (int k = 0; k < 6; k++) begin
      drive(3'b001, 80, 0, 0);
      repeat (4) @(negedge clk);
    end
    chk(stale_o == 3'b110, "R6 two stale", int'(stale_o), 6);
    drive(3'b001, 90, 0, 0);
    for (int k = 0; k < 3; k++) begin
      chk(v_valid_o == 0, "R8 no result with one live", int'(v_valid_o), 0);
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule